// File: doc/BRIEF.md
# Clock Divider Control Register Bank

This block is a 32-bit control register that holds the settings for four fractional clock divider channels, one byte lane per channel. Each lane carries a 6-bit divide code and a gate bit, and the block drives them to the divider datapath. It also drives a decoded enable for each channel and a one-cycle pulse whenever a channel's code changes.

The register appears at four word offsets. Offset 0x0 replaces the whole word. The other three offsets are aliases that set, clear or toggle only the bits written as one. Software can therefore regate or recode one channel without a read-modify-write, and the other lanes are untouched. To retune a channel, software clears its code bits through the clear alias and then writes the new code through the set alias.

The bus is a single-cycle port. A write is taken when `valid_i` and `write_i` are both high on a rising clock edge. Byte address bits 3:2 select the alias, and `rdata_o` always shows the current word.

Top module: `clkdiv_ctrl_regs`

## Requirements
- R1: After reset every lane reads 0x92: gate bit 7 = 1, reserved bit 6 = 0 and divide code = 18. The word is 0x92929292, all channels are disabled and every code output is 18.
- R2: A write with address bits 3:2 = 0 loads the written word into the register.
- R3: A write with address bits 3:2 = 1 ORs the written one-bits into the register. Bits written as zero are unchanged.
- R4: A write with address bits 3:2 = 2 clears every register bit written as one. Bits written as zero are unchanged.
- R5: A write with address bits 3:2 = 3 inverts every register bit written as one. Bits written as zero are unchanged.
- R6: Bit 6 of every lane always reads 0, whatever is written at any offset.
- R7: A write takes effect at the rising edge where `valid_i` and `write_i` are both high. The new value is visible after that edge and not before it. Without both strobes the register holds its value.
- R8: For channel i, `div_code_o[6i+5:6i]` equals lane bits 5:0, `gate_o[i]` equals lane bit 7, and `enable_o[i]` is the inverse of `gate_o[i]`.
- R9: `code_changed_o[i]` is high for exactly the one cycle after an edge at which lane i's code bits changed. It stays low when only the gate bit changes, or when a write leaves the code bits as they were.
- R10: `rdata_o` returns the current register value whatever the address.
- R11: Clearing a channel's code through the clear alias and then writing a new code through the set alias changes only that channel's code. Every other lane keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Bus access strobe |
| write_i | input | 1 | Access is a write |
| addr_i | input | 4 | Byte address; bits 3:2 select the alias |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Current register word |
| div_code_o | output | 24 | Divide code per channel, 6 bits each |
| gate_o | output | 4 | Gate per channel, 1 = stopped |
| enable_o | output | 4 | Channel runs, 1 = running |
| code_changed_o | output | 4 | One-cycle pulse when a channel code changes |

## Verification
The bench builds the block with its defaults: four channels, 6-bit codes and a reset code of 18. At these values the real 32-bit lane layout is exercised, including writes that try to set the reserved bit in several lanes at once. It drives each alias in turn against a bench-side model of the word. It checks the per-lane code-change pulses against writes that change only gate bits, writes that change nothing, and a clear-then-set retune of a single channel.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int LANE_W   = 8;
  localparam int GATE_BIT = 7;
  localparam int RSV_BIT  = 6;

  typedef enum logic [1:0] {
    ALIAS_WRITE = 2'd0,
    ALIAS_SET   = 2'd1,
    ALIAS_CLR   = 2'd2,
    ALIAS_TOG   = 2'd3
  } alias_op_e;
endpackage

// File: rtl/clkdiv_alias_dec.sv
module clkdiv_alias_dec
  import clkdiv_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_en_o,
  output alias_op_e         op_o
);
  logic unused_addr;

  assign wr_en_o     = valid_i & write_i;
  assign op_o        = alias_op_e'(addr_i[3:2]);
  assign unused_addr = ^{addr_i[1:0], addr_i[ADDR_W-1:2]};
endmodule

// File: rtl/clkdiv_lane.sv
module clkdiv_lane
  import clkdiv_pkg::*;
#(
  parameter int          CODE_W     = 6,
  parameter logic [5:0]  RESET_CODE = 6'd18
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  alias_op_e           op_i,
  input  logic [LANE_W-1:0]   wdata_i,
  output logic [LANE_W-1:0]   lane_o,
  output logic [CODE_W-1:0]   code_o,
  output logic                gate_o,
  output logic                code_changed_o
);
  logic              gate_q, gate_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              w_gate;
  logic [CODE_W-1:0] w_code;
  logic              unused_w;

  assign w_gate   = wdata_i[GATE_BIT];
  assign w_code   = wdata_i[CODE_W-1:0];
  assign unused_w = ^wdata_i;

  always_comb begin
    unique case (op_i)
      ALIAS_WRITE: begin gate_d = w_gate;          code_d = w_code;           end
      ALIAS_SET:   begin gate_d = gate_q | w_gate; code_d = code_q | w_code;  end
      ALIAS_CLR:   begin gate_d = gate_q & ~w_gate; code_d = code_q & ~w_code; end
      default:     begin gate_d = gate_q ^ w_gate; code_d = code_q ^ w_code;  end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q         <= 1'b1;
      code_q         <= RESET_CODE[CODE_W-1:0];
      code_changed_o <= 1'b0;
    end else begin
      code_changed_o <= wr_en_i && (code_d != code_q);
      if (wr_en_i) begin
        gate_q <= gate_d;
        code_q <= code_d;
      end
    end
  end

  always_comb begin
    lane_o                 = '0;
    lane_o[GATE_BIT]       = gate_q;
    lane_o[CODE_W-1:0]     = code_q;
  end
  assign code_o = code_q;
  assign gate_o = gate_q;

  AST_LANE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> $stable(lane_o)); // R7
  AST_CHG_MEANS_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_changed_o |-> (code_q != $past(code_q))); // R9
endmodule

// File: rtl/clkdiv_ctrl_regs.sv
module clkdiv_ctrl_regs
  import clkdiv_pkg::*;
#(
  parameter int         NUM_CH     = 4,
  parameter int         CODE_W     = 6,
  parameter logic [5:0] RESET_CODE = 6'd18,
  parameter int         ADDR_W     = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     write_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [NUM_CH*LANE_W-1:0] wdata_i,
  output logic [NUM_CH*LANE_W-1:0] rdata_o,
  output logic [NUM_CH*CODE_W-1:0] div_code_o,
  output logic [NUM_CH-1:0]        gate_o,
  output logic [NUM_CH-1:0]        enable_o,
  output logic [NUM_CH-1:0]        code_changed_o
);
  localparam int DATA_W = NUM_CH * LANE_W;

  logic      wr_en;
  alias_op_e op;

  clkdiv_alias_dec #(.ADDR_W(ADDR_W)) u_dec (
    .valid_i (valid_i),
    .write_i (write_i),
    .addr_i  (addr_i),
    .wr_en_o (wr_en),
    .op_o    (op)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
    clkdiv_lane #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_lane (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .wr_en_i        (wr_en),
      .op_i           (op),
      .wdata_i        (wdata_i[i*LANE_W +: LANE_W]),
      .lane_o         (rdata_o[i*LANE_W +: LANE_W]),
      .code_o         (div_code_o[i*CODE_W +: CODE_W]),
      .gate_o         (gate_o[i]),
      .code_changed_o (code_changed_o[i])
    );
  end

  assign enable_o = ~gate_o;

  AST_SET_ONLY_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en) && $past(op) == ALIAS_SET) |-> ((rdata_o & $past(rdata_o)) == $past(rdata_o))); // R3
  AST_CLR_ONLY_LOWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en) && $past(op) == ALIAS_CLR) |-> ((rdata_o | $past(rdata_o)) == $past(rdata_o))); // R4
  AST_CLR_HITS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en) && $past(op) == ALIAS_CLR) |-> ((rdata_o & $past(wdata_i)) == '0)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en) |-> (rdata_o == $past(rdata_o) && code_changed_o == '0)); // R7

  logic unused_w;
  assign unused_w = ^DATA_W;
endmodule

// File: tb/clkdiv_ctrl_regs_tb.sv
`timescale 1ns/1ps
module clkdiv_ctrl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [23:0] div_code;
  logic [3:0]  gate, enable, chg;

  int n_run = 0, n_fail = 0;
  logic [31:0] model;
  bit done = 0;

  always #2.5 clk = ~clk;

  clkdiv_ctrl_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .write_i(write),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .div_code_o(div_code),
    .gate_o(gate), .enable_o(enable), .code_changed_o(chg)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] apply(logic [1:0] op, logic [31:0] cur, logic [31:0] w);
    logic [31:0] n;
    case (op)
      2'd0: n = w;
      2'd1: n = cur | w;
      2'd2: n = cur & ~w;
      default: n = cur ^ w;
    endcase
    return n & 32'hBFBF_BFBF;
  endfunction

  function automatic logic [3:0] code_diff(logic [31:0] a, logic [31:0] b);
    logic [3:0] d;
    for (int i = 0; i < 4; i++) d[i] = (a[i*8 +: 6] != b[i*8 +: 6]);
    return d;
  endfunction

  task automatic check_fields(string req);
    for (int i = 0; i < 4; i++) begin
      check(req, {26'd0, div_code[i*6 +: 6]}, {26'd0, model[i*8 +: 6]});
      check(req, {31'd0, gate[i]}, {31'd0, model[i*8+7]});
      check(req, {31'd0, enable[i]}, {31'd0, ~model[i*8+7]});
    end
  endtask

  // drive at negedge, take at posedge, sample at following negedge
  task automatic bus_write(logic [3:0] a, logic [31:0] d, string req);
    logic [31:0] prev;
    @(negedge clk);
    valid = 1; write = 1; addr = a; wdata = d;
    check({req, " R7 pre-edge"}, rdata, model);
    prev  = model;
    model = apply(a[3:2], model, d);
    @(negedge clk);
    valid = 0; write = 0;
    check(req, rdata, model);
    check({req, " R9 pulse"}, {28'd0, chg}, {28'd0, code_diff(prev, model)});
    check({req, " R6"}, rdata & 32'h4040_4040, 32'd0);
  endtask

  task automatic t_reset;
    model = 32'h9292_9292;
    check("R1 word", rdata, model);
    check("R1 enable", {28'd0, enable}, 32'd0);
    check_fields("R1 fields");
  endtask

  task automatic t_plain;
    bus_write(4'h0, 32'h5F41_23FF, "R2 plain");
    check("R2 R6 value", rdata, 32'h1F01_23BF);
  endtask

  task automatic t_set;
    bus_write(4'h4, 32'h4080_8000, "R3 set");
    check("R3 value", rdata, 32'h1F81_A3BF);
    check("R9 gate only no pulse", {28'd0, chg}, 32'd0);
  endtask

  task automatic t_clr;
    bus_write(4'h8, 32'h0000_8080, "R4 clr");
    check("R4 value", rdata, 32'h1F81_233F);
    check("R8 enable", {28'd0, enable}, 32'hB);
    check("R8 gate", {28'd0, gate}, 32'h4);
    check_fields("R8 fields");
  endtask

  task automatic t_tog;
    bus_write(4'hC, 32'h0000_00FF, "R5 tog");
    check("R5 value", rdata, 32'h1F81_2380);
    check("R9 lane0 pulse", {28'd0, chg}, 32'h1);
    @(negedge clk);
    check("R9 pulse one cycle", {28'd0, chg}, 32'd0);
  endtask

  task automatic t_same_code;
    bus_write(4'h4, 32'h0000_2300, "R9 same code");
    check("R9 no change no pulse", {28'd0, chg}, 32'd0);
  endtask

  task automatic t_retune;
    bus_write(4'h8, 32'h003F_0000, "R11 clr code");
    check("R11 after clr", rdata, 32'h1F80_2380);
    check("R9 lane2 pulse", {28'd0, chg}, 32'h4);
    bus_write(4'h4, 32'h0023_0000, "R11 set code");
    check("R11 after set", rdata, 32'h1FA3_2380);
    check("R11 code2", {26'd0, div_code[12 +: 6]}, 32'd35);
    check_fields("R11 fields");
  endtask

  task automatic t_no_write;
    @(negedge clk);
    valid = 1; write = 0; addr = 4'h4; wdata = '1;
    @(negedge clk);
    check("R7 read only holds", rdata, model);
    valid = 0; write = 1; addr = 4'h0; wdata = '0;
    @(negedge clk);
    check("R7 no valid holds", rdata, model);
    check("R7 no pulse", {28'd0, chg}, 32'd0);
    write = 0;
  endtask

  task automatic t_read_alias;
    for (int a = 0; a < 16; a += 4) begin
      @(negedge clk);
      valid = 1; write = 0; addr = a[3:0];
      #1 check("R10 read any offset", rdata, model);
    end
    valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_set();
    t_clr();
    t_tog();
    t_same_code();
    t_retune();
    t_no_write();
    t_read_alias();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule